// File: doc/BRIEF.md
# Epoch-Aware Hit Stream Concentrator

This block takes several record streams, each produced by one self-triggered front-end chip and each already in time order, and merges them into one output stream that is also in time order. A stream is made of two kinds of 32-bit records. Epoch markers carry an absolute coarse time. Hit records carry a timestamp relative to the most recent marker, plus a channel address and an amplitude. The concentrator sends one marker per epoch, even when several inputs carry the same marker. Between two markers it interleaves the hits from all inputs in ascending timestamp order.

Every input passes through a small FIFO. The merge core looks at the head of each FIFO. It releases the earliest hit only once every live input has shown it either a hit or its next marker. When all live inputs are waiting on markers, it sends the lowest pending epoch and consumes every head that carries that epoch. An idle timer on each input stops one silent link from stalling the output. The index of the input port is written into the upper bits of each hit's channel address, so the source of every hit can still be identified. All inputs and the output use valid/ready handshakes.

Top module: `hsc_concentrator`

## Requirements
- R1: Between two output markers, output hits appear in non-decreasing timestamp order, merged across all inputs.
- R2: A marker that several inputs carry for the same epoch is sent only once. Output marker epochs strictly increase.
- R3: Hits with equal timestamps in the same epoch leave in ascending input-port order.
- R4: Record encoding: bit 31 = 1 marks an epoch marker, whose bits [30:0] hold the epoch. Bit 31 = 0 marks a hit, laid out as timestamp [30:18], channel [17:8] and amplitude [7:0]. On output, channel bits [17:16] are replaced by the input port index. Timestamp, amplitude and channel bits [15:8] pass through unchanged, and the input values of bits [17:16] are ignored.
- R5: When live inputs wait on different markers, the lowest epoch is sent and only the heads that carry it are consumed. An input that skips an epoch waits at its later marker without blocking.
- R6: Nothing is released while any input has an empty FIFO and has not yet timed out.
- R7: An input whose FIFO has stayed empty for IDLE_LIMIT cycles is left out of the merge decisions until it delivers data again.
- R8: A marker whose epoch is at or below the last epoch sent (for example, from an input that returns after a timeout) is consumed and produces no output.
- R9: The output holds out_data stable while out_valid is high and out_ready is low. No record is lost or duplicated under backpressure.
- R10: After reset, out_valid is low and every input FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NUM_IN | Per-input record valid |
| in_data | input | NUM_IN x 32 | Per-input record |
| in_ready | output | NUM_IN | Per-input FIFO has space |
| out_valid | output | 1 | Merged record valid |
| out_data | output | 32 | Merged record |
| out_ready | input | 1 | Downstream accepts the merged record |

## Verification
The bench builds the block with four inputs, FIFOs four deep, and IDLE_LIMIT reduced to 32. The short limit lets one run cover both behaviours. A late input holds the merge back (R6), while inputs that stay silent across the gaps between scenarios time out and are bypassed (R7). A returning input can then show a stale marker (R8). The shallow FIFOs fill quickly, so random backpressure on the output also stalls the input handshakes. Combined with epoch skips and equal-timestamp ties, this exercises every branch of the selection logic.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
    parameter int REC_W = 32;
    parameter int TS_W  = 13;
    parameter int CH_W  = 10;
    parameter int AMP_W = 8;

    localparam int EP_W   = REC_W - 1;
    localparam int CH_LSB = AMP_W;
    localparam int TS_LSB = AMP_W + CH_W;

    typedef struct packed {
        logic             started;
        logic [EP_W-1:0]  cur_ep;
        logic             out_valid;
        logic [REC_W-1:0] out_data;
    } merge_state_t;
endpackage

// File: rtl/hsc_fifo.sv
module hsc_fifo
    import hsc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [REC_W-1:0] push_data,
    output logic             push_ready,
    input  logic             pop,
    output logic             head_valid,
    output logic [REC_W-1:0] head_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][REC_W-1:0] mem;
        logic [AW-1:0]               wr;
        logic [AW-1:0]               rd;
        logic [CW-1:0]               cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ready = (st_q.cnt != CW'(DEPTH));
    assign head_valid = (st_q.cnt != '0);
    assign head_data  = st_q.mem[st_q.rd];
    assign do_push    = push_valid && push_ready;
    assign do_pop     = pop && head_valid;

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = bump(st_q.wr);
        end
        if (do_pop) st_d.rd = bump(st_q.rd);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: the merge core only consumes heads that exist
    a_r6_pop_has_head: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> st_q.cnt != '0);
    // R9: occupancy never exceeds the depth
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
endmodule

// File: rtl/hsc_idle_timer.sv
module hsc_idle_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic empty,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             at_limit;

    assign at_limit = (cnt_q == CNT_W'(LIMIT));
    assign expired  = at_limit && empty;

    always_comb begin
        cnt_d = cnt_q;
        if (!empty)         cnt_d = '0;
        else if (!at_limit) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7: a timeout is only ever reached after an empty cycle
    a_r7_expiry_follows_empty: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> $past(empty));
endmodule

// File: rtl/hsc_select.sv
module hsc_select
    import hsc_pkg::*;
#(
    parameter int NUM_IN = 4,
    parameter int PORT_W = 2
) (
    input  logic [NUM_IN-1:0]           is_hit,
    input  logic [NUM_IN-1:0]           is_mark,
    input  logic [NUM_IN-1:0][TS_W-1:0] ts,
    input  logic [NUM_IN-1:0][EP_W-1:0] ep,
    output logic                        hit_any,
    output logic [PORT_W-1:0]           hit_idx,
    output logic                        mark_any,
    output logic [EP_W-1:0]             mark_ep,
    output logic [NUM_IN-1:0]           mark_match
);
    logic [TS_W-1:0] best_ts;

    always_comb begin
        hit_any  = 1'b0;
        hit_idx  = '0;
        best_ts  = '0;
        mark_any = 1'b0;
        mark_ep  = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            // strict compare keeps the lowest port on ties
            if (is_hit[i] && (!hit_any || ts[i] < best_ts)) begin
                hit_any = 1'b1;
                hit_idx = PORT_W'(i);
                best_ts = ts[i];
            end
            if (is_mark[i] && (!mark_any || ep[i] < mark_ep)) begin
                mark_any = 1'b1;
                mark_ep  = ep[i];
            end
        end
        for (int i = 0; i < NUM_IN; i++) begin
            mark_match[i] = is_mark[i] && (ep[i] == mark_ep);
        end
    end
endmodule

// File: rtl/hsc_concentrator.sv
module hsc_concentrator
    import hsc_pkg::*;
#(
    parameter int NUM_IN     = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int IDLE_LIMIT = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_IN-1:0]            in_valid,
    input  logic [NUM_IN-1:0][REC_W-1:0] in_data,
    output logic [NUM_IN-1:0]            in_ready,
    output logic                         out_valid,
    output logic [REC_W-1:0]             out_data,
    input  logic                         out_ready
);
    localparam int PORT_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
    localparam int KEEP_W = CH_W - PORT_W;

    logic [NUM_IN-1:0]             head_v, expired, pop;
    logic [NUM_IN-1:0]             is_hit, is_mark, blocked;
    logic [NUM_IN-1:0][REC_W-1:0]  head;
    logic [NUM_IN-1:0][TS_W-1:0]   head_ts;
    logic [NUM_IN-1:0][EP_W-1:0]   head_ep;
    logic                          hit_any, mark_any;
    logic [PORT_W-1:0]             hit_idx;
    logic [EP_W-1:0]               mark_ep;
    logic [NUM_IN-1:0]             mark_match;
    logic [REC_W-1:0]              sel_rec, hit_out;
    logic                          out_free, load_hit, load_mark;

    merge_state_t st_d, st_q;

    for (genvar g = 0; g < NUM_IN; g++) begin : g_in
        hsc_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_valid (in_valid[g]),
            .push_data  (in_data[g]),
            .push_ready (in_ready[g]),
            .pop        (pop[g]),
            .head_valid (head_v[g]),
            .head_data  (head[g])
        );
        hsc_idle_timer #(.LIMIT(IDLE_LIMIT)) u_idle (
            .clk     (clk),
            .rst_n   (rst_n),
            .empty   (!head_v[g]),
            .expired (expired[g])
        );
        assign is_mark[g] = head_v[g] && head[g][REC_W-1];
        assign is_hit[g]  = head_v[g] && !head[g][REC_W-1];
        assign blocked[g] = !head_v[g] && !expired[g];
        assign head_ts[g] = head[g][TS_LSB +: TS_W];
        assign head_ep[g] = head[g][EP_W-1:0];
    end

    hsc_select #(.NUM_IN(NUM_IN), .PORT_W(PORT_W)) u_sel (
        .is_hit     (is_hit),
        .is_mark    (is_mark),
        .ts         (head_ts),
        .ep         (head_ep),
        .hit_any    (hit_any),
        .hit_idx    (hit_idx),
        .mark_any   (mark_any),
        .mark_ep    (mark_ep),
        .mark_match (mark_match)
    );

    assign sel_rec = head[hit_idx];
    assign hit_out = {1'b0, sel_rec[TS_LSB +: TS_W], hit_idx,
                      sel_rec[CH_LSB +: KEEP_W], sel_rec[AMP_W-1:0]};

    always_comb begin
        st_d      = st_q;
        pop       = '0;
        load_hit  = 1'b0;
        load_mark = 1'b0;
        out_free  = !st_q.out_valid || out_ready;
        if (out_ready) st_d.out_valid = 1'b0;
        if (blocked == '0) begin
            if (hit_any) begin
                if (out_free) begin
                    load_hit       = 1'b1;
                    pop[hit_idx]   = 1'b1;
                    st_d.out_valid = 1'b1;
                    st_d.out_data  = hit_out;
                end
            end else if (mark_any) begin
                if (st_q.started && mark_ep <= st_q.cur_ep) begin
                    pop = mark_match;
                end else if (out_free) begin
                    load_mark      = 1'b1;
                    pop            = mark_match;
                    st_d.out_valid = 1'b1;
                    st_d.out_data  = {1'b1, mark_ep};
                    st_d.cur_ep    = mark_ep;
                    st_d.started   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.out_valid;
    assign out_data  = st_q.out_data;

    // R9: a stalled output beat is held unchanged
    a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    // R2: each sent marker opens a newer epoch than the last one
    a_r2_epoch_advances: assert property (@(posedge clk) disable iff (!rst_n)
        load_mark && st_q.started |-> mark_ep > st_q.cur_ep);
    // R6: at most one hit head is consumed per cycle
    a_r6_single_hit_pop: assert property (@(posedge clk) disable iff (!rst_n)
        load_hit |-> $countones(pop) == 1);

    for (genvar g = 0; g < NUM_IN; g++) begin : g_chk
        // R1: the released hit is no later than any other hit head
        a_r1_earliest_hit: assert property (@(posedge clk) disable iff (!rst_n)
            load_hit && is_hit[g] |-> head_ts[hit_idx] <= head_ts[g]);
        // R3: on equal timestamps the lower port is released first
        a_r3_tie_low_port: assert property (@(posedge clk) disable iff (!rst_n)
            load_hit && is_hit[g] && head_ts[g] == head_ts[hit_idx]
            |-> hit_idx <= PORT_W'(g));
    end
endmodule

// File: tb/hsc_concentrator_tb.sv
module hsc_concentrator_tb_top;
    import hsc_pkg::*;

    localparam int N   = 4;
    localparam int LIM = 32;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic [N-1:0]            in_valid;
    logic [N-1:0][REC_W-1:0] in_data;
    logic [N-1:0]            in_ready;
    logic                    out_valid;
    logic [REC_W-1:0]        out_data;
    logic                    out_ready;

    always #2 clk = ~clk;

    hsc_concentrator #(.NUM_IN(N), .FIFO_DEPTH(4), .IDLE_LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready)
    );

    logic [REC_W-1:0] src_q [N][$];
    logic [REC_W-1:0] exp_q [$];
    int   dly [N];
    logic rdy_seen [N];
    int   n_chk, n_bad, beats, early_out;
    logic bp_en, watch_late, running;
    logic [7:0] lfsr;

    function automatic logic [31:0] mk_mark(int ep);
        return {1'b1, 31'(ep)};
    endfunction
    function automatic logic [31:0] mk_hit(int ts, int ch, int amp);
        return {1'b0, 13'(ts), 10'(ch), 8'(amp)};
    endfunction
    function automatic logic [31:0] xp_hit(int ts, int port, int ch, int amp);
        return {1'b0, 13'(ts), 2'(port), 8'(ch), 8'(amp)};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic push_in(input int i, input logic [31:0] r);
        src_q[i].push_back(r);
    endtask
    task automatic expect_rec(input logic [31:0] r);
        exp_q.push_back(r);
    endtask

    task automatic finish_test(input int n_exp, input string tag);
        int guard = 0;
        while ((exp_q.size() != 0 || src_q[0].size() != 0 || src_q[1].size() != 0 ||
                src_q[2].size() != 0 || src_q[3].size() != 0) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (100) @(negedge clk);
        check(beats == n_exp && exp_q.size() == 0, tag, 32'(beats), 32'(n_exp));
        beats = 0;
        exp_q.delete();
    endtask

    // driver and monitor, all sampling away from the active edge
    always @(negedge clk) begin
        if (running) begin
            for (int i = 0; i < N; i++) begin
                if (in_valid[i] && rdy_seen[i]) void'(src_q[i].pop_front());
                if (dly[i] > 0) begin
                    dly[i]--;
                    in_valid[i] = 1'b0;
                end else if (src_q[i].size() > 0) begin
                    in_valid[i] = 1'b1;
                    in_data[i]  = src_q[i][0];
                end else begin
                    in_valid[i] = 1'b0;
                end
                rdy_seen[i] = in_ready[i];
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = bp_en ? lfsr[0] : 1'b1;
            if (watch_late && dly[3] > 0 && out_valid) early_out++;
            if (out_valid && out_ready) begin
                beats++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2/R9 unexpected output beat", out_data, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check(out_data == e, "R1/R2/R3/R4/R5/R8/R9 merged stream", out_data, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog expired: got hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        n_chk = 0; n_bad = 0; beats = 0; early_out = 0;
        bp_en = 1'b0; watch_late = 1'b0; running = 1'b0;
        lfsr = 8'h5B; out_ready = 1'b1;
        in_valid = '0; in_data = '0;
        for (int i = 0; i < N; i++) begin
            dly[i] = 0;
            rdy_seen[i] = 1'b0;
        end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(out_valid == 1'b0, "R10 out_valid in reset", 32'(out_valid), 32'h0);
        check(in_ready == 4'hF, "R10 fifos empty in reset", 32'(in_ready), 32'hF);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R10 out_valid after reset", 32'(out_valid), 32'h0);
        running = 1'b1;

        // Scenario A: ties, interleaving, duplicate markers, late input 3 (R1 R2 R3 R4 R6)
        watch_late = 1'b1;
        dly[3] = 12;
        push_in(0, mk_mark(1)); push_in(0, mk_hit(10, 1, 8'h11)); push_in(0, mk_hit(40, 2, 8'h12));
        push_in(0, mk_mark(2)); push_in(0, mk_hit(5, 3, 8'h13)); push_in(0, mk_mark(3));
        push_in(1, mk_mark(1)); push_in(1, mk_hit(20, 1, 8'h21)); push_in(1, mk_mark(2));
        push_in(1, mk_mark(3));
        push_in(2, mk_mark(1)); push_in(2, mk_hit(10, 4, 8'h31)); push_in(2, mk_hit(30, 5, 8'h32));
        push_in(2, mk_mark(2)); push_in(2, mk_hit(5, 6, 8'h33)); push_in(2, mk_hit(9, 7, 8'h34));
        push_in(2, mk_mark(3));
        push_in(3, mk_mark(1)); push_in(3, mk_mark(2)); push_in(3, mk_hit(1, 2, 8'h41));
        push_in(3, mk_mark(3));
        expect_rec(mk_mark(1));
        expect_rec(xp_hit(10, 0, 1, 8'h11));
        expect_rec(xp_hit(10, 2, 4, 8'h31));   // R3 tie
        expect_rec(xp_hit(20, 1, 1, 8'h21));
        expect_rec(xp_hit(30, 2, 5, 8'h32));
        expect_rec(xp_hit(40, 0, 2, 8'h12));
        expect_rec(mk_mark(2));                // R2 single marker
        expect_rec(xp_hit(1, 3, 2, 8'h41));
        expect_rec(xp_hit(5, 0, 3, 8'h13));
        expect_rec(xp_hit(5, 2, 6, 8'h33));
        expect_rec(xp_hit(9, 2, 7, 8'h34));
        expect_rec(mk_mark(3));
        finish_test(12, "R1 scenario A beat count");
        watch_late = 1'b0;
        check(early_out == 0, "R6 output while input 3 was still empty", 32'(early_out), 32'h0);

        // Scenario B: backpressure and an epoch skip on input 0 (R5 R9)
        bp_en = 1'b1;
        push_in(0, mk_mark(4)); push_in(0, mk_hit(100, 1, 8'h01)); push_in(0, mk_mark(5));
        push_in(0, mk_mark(7));
        push_in(1, mk_mark(4)); push_in(1, mk_hit(50, 2, 8'h02)); push_in(1, mk_hit(100, 3, 8'h03));
        push_in(1, mk_mark(5)); push_in(1, mk_hit(3, 4, 8'h04)); push_in(1, mk_mark(6));
        push_in(1, mk_hit(8, 5, 8'h05)); push_in(1, mk_mark(7));
        push_in(2, mk_mark(4)); push_in(2, mk_mark(5)); push_in(2, mk_mark(6));
        push_in(2, mk_hit(2, 6, 8'h06)); push_in(2, mk_mark(7));
        push_in(3, mk_mark(4)); push_in(3, mk_hit(50, 7, 8'h07)); push_in(3, mk_mark(5));
        push_in(3, mk_mark(6)); push_in(3, mk_hit(8, 8, 8'h08)); push_in(3, mk_mark(7));
        expect_rec(mk_mark(4));
        expect_rec(xp_hit(50, 1, 2, 8'h02));
        expect_rec(xp_hit(50, 3, 7, 8'h07));
        expect_rec(xp_hit(100, 0, 1, 8'h01));
        expect_rec(xp_hit(100, 1, 3, 8'h03));
        expect_rec(mk_mark(5));
        expect_rec(xp_hit(3, 1, 4, 8'h04));
        expect_rec(mk_mark(6));                // R5 lowest epoch first
        expect_rec(xp_hit(2, 2, 6, 8'h06));
        expect_rec(xp_hit(8, 1, 5, 8'h05));
        expect_rec(xp_hit(8, 3, 8, 8'h08));
        expect_rec(mk_mark(7));
        finish_test(12, "R5 scenario B beat count");
        bp_en = 1'b0;

        // Scenario C: input 3 silent and timed out; reserved channel bits overwritten (R7 R4)
        push_in(0, mk_mark(20)); push_in(0, mk_hit(7, 1, 8'h51)); push_in(0, mk_mark(21));
        push_in(1, mk_mark(20)); push_in(1, mk_hit(7, 2, 8'h52)); push_in(1, mk_hit(9, 10'h3F3, 8'h53));
        push_in(1, mk_mark(21));
        push_in(2, mk_mark(20)); push_in(2, mk_mark(21));
        expect_rec(mk_mark(20));
        expect_rec(xp_hit(7, 0, 1, 8'h51));
        expect_rec(xp_hit(7, 1, 2, 8'h52));
        expect_rec(xp_hit(9, 1, 8'hF3, 8'h53)); // R4 port replaces bits [17:16]
        expect_rec(mk_mark(21));
        finish_test(5, "R7 scenario C beat count");

        // Scenario D: input 3 returns with a stale marker (R8)
        push_in(3, mk_mark(20)); push_in(3, mk_hit(7, 9, 8'h61)); push_in(3, mk_mark(22));
        expect_rec(xp_hit(7, 3, 9, 8'h61));
        expect_rec(mk_mark(22));
        finish_test(2, "R8 scenario D beat count");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule